// File: doc/BRIEF.md
# Halt and Shutdown Special-Cycle Bus Controller

This block is the processor-side sequencer that announces a halt (or a shutdown) to the system bus and then keeps the core parked. When the core raises a halt or shutdown request, the block runs one non-pipelined special bus cycle. The cycle has an address strobe for a single T1 state, followed by T2 states that repeat until the ready input is sampled low. Halt and shutdown share one cycle-definition encoding and differ only in which single byte lane is enabled.

Once the cycle has been acknowledged, the core stays halted. The only ways out are a maskable interrupt request while the interrupt-enable flag is set, a non-maskable interrupt, or reset. Leaving the halted state produces a one-cycle resume pulse. Bus hold requests are still honoured in the idle and halted states: the block floats its bus outputs and raises hold acknowledge. A wake event that arrives during a hold is remembered and acted on once the hold is released.

States: `ST_IDLE`, `ST_IDLE_HOLD`, `ST_T1`, `ST_T2`, `ST_HALTED`, `ST_HALT_HOLD`, `ST_RESUME`. The transitions are:

- IDLE→IDLE_HOLD on hold.
- IDLE→T1 on a request when no hold is present.
- IDLE_HOLD→IDLE when hold drops.
- T1→T2 always.
- T2→HALTED on ready.
- T2→HALT_HOLD on ready with hold.
- HALTED→HALT_HOLD on hold.
- HALTED→RESUME on wake.
- HALT_HOLD→RESUME when hold drops with a wake seen.
- HALT_HOLD→HALTED when hold drops without a wake.
- RESUME→IDLE always.
- Any state→IDLE on reset.

Top module: `halt_cycle_ctrl`

## Requirements
- R1: Reset is asynchronous and active high. While it is asserted, and at once from any state, the outputs take their idle values: `ads_n`=1, `be_n`=4'b1111, `bus_oe`=1, `data_oe`=0, `hlda`=0, `resume`=0.
- R2: In idle with no hold, a halt request sampled at a clock edge starts T1 in the next cycle. In T1, `ads_n`=0, `mio`=1, `dc`=0, `wr`=1, `addr`=0 and `data_oe`=1. `ads_n` is low for exactly one cycle.
- R3: A halt cycle drives `be_n`=4'b1011, which is byte address 2 on lane 2. A shutdown cycle drives `be_n`=4'b1110, which is byte address 0 on lane 0. If both requests are present in the same cycle, shutdown wins.
- R4: Each T2 state in which `rdy_n` is sampled high is followed by another T2 state. Throughout T2, `ads_n`=1 and the cycle definition and byte enables are held unchanged.
- R5: `rdy_n` sampled low in T2 ends the cycle, so that the next cycle is halted with `data_oe`=0 and `be_n`=4'b1111. `rdy_n` low during T1 has no effect, because T1 always lasts exactly one cycle.
- R6: While halted, the block stays halted with no bus activity when `intr` is high and `if_flag` is 0. New halt requests are also ignored.
- R7: While halted with no hold, `nmi`, or `intr` with `if_flag`=1, gives `resume`=1 for exactly the next cycle, after which the block is idle.
- R8: A hold sampled in idle or halted gives `hlda`=1, `bus_oe`=0 and `data_oe`=0 in the next cycle. When hold is sampled low, `hlda` returns to 0 in the next cycle and the prior state resumes.
- R9: Hold is not granted during T1 or T2. If hold is present when ready ends the cycle, `hlda`=1 in the very next cycle.
- R10: A wake event sampled during a halted hold, or in the same cycle that hold is taken, is kept. It produces the resume pulse in the cycle after hold is released, with no further wake needed.
- R11: A request that arrives while hold is active in idle starts no cycle until hold is released. After release, a request that is still present starts T1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset, also a wake source |
| halt_req | input | 1 | Core requests a halt special cycle (level) |
| shut_req | input | 1 | Core requests a shutdown special cycle (level) |
| rdy_n | input | 1 | Active-low bus cycle acknowledge |
| intr | input | 1 | Maskable interrupt request |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| nmi | input | 1 | Non-maskable interrupt |
| hold | input | 1 | Bus hold request |
| ads_n | output | 1 | Active-low address strobe |
| be_n | output | 4 | Active-low byte enables |
| mio | output | 1 | Memory/IO cycle definition |
| dc | output | 1 | Data/control cycle definition |
| wr | output | 1 | Write/read cycle definition |
| addr | output | 30 | Word address |
| data | output | 32 | Write data, no defined meaning in the special cycle |
| bus_oe | output | 1 | Drive enable for address and control, low while floated |
| data_oe | output | 1 | Drive enable for the data bus |
| hlda | output | 1 | Hold acknowledge |
| resume | output | 1 | One-cycle pulse telling the core to resume execution |

## Verification
Two functions can fall in the same cycle: taking a bus hold and recognising a wake event. One case is hold and an enabled interrupt sampled at the same edge while halted. The other is hold already present at the edge where ready ends the special cycle, with NMI arriving later during the hold. In each case the bench checks that hold acknowledge wins at once and that no resume appears while hold is active. It then checks that the resume pulse appears in exactly the cycle after hold falls, even though the wake input was already low by then. Hold during T1 and T2 is also driven, to show that acknowledge is withheld until the cycle completes.

// File: rtl/halt_cycle_pkg.sv
package halt_cycle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDLE_HOLD,
        ST_T1,
        ST_T2,
        ST_HALTED,
        ST_HALT_HOLD,
        ST_RESUME
    } hc_state_e;

    typedef enum logic {
        KIND_HALT,
        KIND_SHUT
    } hc_kind_e;

    // byte lanes that identify each special cycle
    localparam int HALT_LANE = 2;
    localparam int SHUT_LANE = 0;

endpackage

// File: rtl/halt_wake_qual.sv
module halt_wake_qual (
    input  logic intr,
    input  logic if_flag,
    input  logic nmi,
    output logic wake
);

    logic maskable_ok;

    always_comb begin
        maskable_ok = intr && if_flag;
        wake        = maskable_ok || nmi;
    end

endmodule

// File: rtl/halt_cycle_fsm.sv
module halt_cycle_fsm
    import halt_cycle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      shut_req,
    input  logic      rdy_n,
    input  logic      hold,
    input  logic      wake,
    output hc_state_e state,
    output hc_kind_e  kind
);

    hc_state_e state_d;
    hc_kind_e  kind_d;
    logic      pend_q;
    logic      pend_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind   <= KIND_HALT;
            pend_q <= 1'b0;
        end else begin
            state  <= state_d;
            kind   <= kind_d;
            pend_q <= pend_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state;
        kind_d  = kind;
        pend_d  = pend_q;
        unique case (state)
            ST_IDLE: begin
                if (hold) begin
                    state_d = ST_IDLE_HOLD;
                end else if (shut_req || halt_req) begin
                    state_d = ST_T1;
                    kind_d  = shut_req ? KIND_SHUT : KIND_HALT;
                end
            end
            ST_IDLE_HOLD: begin
                if (!hold) state_d = ST_IDLE;
            end
            ST_T1: begin
                state_d = ST_T2;
            end
            ST_T2: begin
                if (!rdy_n) state_d = hold ? ST_HALT_HOLD : ST_HALTED;
            end
            ST_HALTED: begin
                if (hold) begin
                    state_d = ST_HALT_HOLD;
                    pend_d  = wake;
                end else if (wake) begin
                    state_d = ST_RESUME;
                end
            end
            ST_HALT_HOLD: begin
                if (!hold) begin
                    state_d = (pend_q || wake) ? ST_RESUME : ST_HALTED;
                    pend_d  = 1'b0;
                end else begin
                    pend_d  = pend_q || wake;
                end
            end
            ST_RESUME: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                pend_d  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/halt_bus_drive.sv
module halt_bus_drive
    import halt_cycle_pkg::*;
#(
    parameter int          ADDR_W    = 30,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DATA_FILL = 32'h0000_0000,
    localparam int         BE_W      = DATA_W / 8
) (
    input  hc_state_e         state,
    input  hc_kind_e          kind,
    output logic              ads_n,
    output logic [BE_W-1:0]   be_n,
    output logic              mio,
    output logic              dc,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              bus_oe,
    output logic              data_oe,
    output logic              hlda,
    output logic              resume
);

    logic in_cycle;
    int   lane_sel;

    // per-state outputs
    always_comb begin
        in_cycle = 1'b0;
        ads_n    = 1'b1;
        mio      = 1'b0;
        dc       = 1'b0;
        wr       = 1'b0;
        bus_oe   = 1'b1;
        data_oe  = 1'b0;
        hlda     = 1'b0;
        resume   = 1'b0;
        unique case (state)
            ST_T1: begin
                in_cycle = 1'b1;
                ads_n    = 1'b0;
                mio      = 1'b1;
                wr       = 1'b1;
                data_oe  = 1'b1;
            end
            ST_T2: begin
                in_cycle = 1'b1;
                mio      = 1'b1;
                wr       = 1'b1;
                data_oe  = 1'b1;
            end
            ST_IDLE_HOLD, ST_HALT_HOLD: begin
                bus_oe   = 1'b0;
                hlda     = 1'b1;
            end
            ST_RESUME: begin
                resume   = 1'b1;
            end
            default: begin
                in_cycle = 1'b0;
            end
        endcase
    end

    always_comb begin
        lane_sel = (kind == KIND_SHUT) ? SHUT_LANE : HALT_LANE;
        addr     = '0;
        data     = DATA_W'(DATA_FILL);
    end

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        always_comb be_n[i] = !(in_cycle && (lane_sel == i));
    end

endmodule

// File: rtl/halt_cycle_ctrl.sv
module halt_cycle_ctrl
    import halt_cycle_pkg::*;
#(
    parameter int          ADDR_W    = 30,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DATA_FILL = 32'h0000_0000,
    localparam int         BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              shut_req,
    input  logic              rdy_n,
    input  logic              intr,
    input  logic              if_flag,
    input  logic              nmi,
    input  logic              hold,
    output logic              ads_n,
    output logic [BE_W-1:0]   be_n,
    output logic              mio,
    output logic              dc,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              bus_oe,
    output logic              data_oe,
    output logic              hlda,
    output logic              resume
);

    logic      wake;
    hc_state_e state;
    hc_kind_e  kind;

    halt_wake_qual u_wake (
        .intr    (intr),
        .if_flag (if_flag),
        .nmi     (nmi),
        .wake    (wake)
    );

    halt_cycle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .halt_req (halt_req),
        .shut_req (shut_req),
        .rdy_n    (rdy_n),
        .hold     (hold),
        .wake     (wake),
        .state    (state),
        .kind     (kind)
    );

    halt_bus_drive #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DATA_FILL (DATA_FILL)
    ) u_drive (
        .state   (state),
        .kind    (kind),
        .ads_n   (ads_n),
        .be_n    (be_n),
        .mio     (mio),
        .dc      (dc),
        .wr      (wr),
        .addr    (addr),
        .data    (data),
        .bus_oe  (bus_oe),
        .data_oe (data_oe),
        .hlda    (hlda),
        .resume  (resume)
    );

endmodule

// File: rtl/halt_cycle_chk.sv
module halt_cycle_chk #(
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            rdy_n,
    input logic            ads_n,
    input logic [BE_W-1:0] be_n,
    input logic            mio,
    input logic            dc,
    input logic            wr,
    input logic            bus_oe,
    input logic            data_oe,
    input logic            hlda,
    input logic            resume
);

    AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> ads_n);  // R2

    AST_CYCLE_DEF: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (mio && !dc && wr));  // R2

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $countones(~be_n) <= 1);  // R3

    AST_WAIT_STATE: assert property (@(posedge clk) disable iff (rst)
        (data_oe && ads_n && rdy_n) |=> (data_oe && ads_n && $stable(be_n)));  // R4

    AST_READY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (data_oe && ads_n && !rdy_n) |=> !data_oe);  // R5

    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);  // R7

    AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!bus_oe && !data_oe));  // R8

    AST_NO_GRANT_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !hlda);  // R9

    AST_NO_RESUME_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !resume);  // R10

endmodule

bind halt_cycle_ctrl halt_cycle_chk #(.BE_W(BE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rdy_n   (rdy_n),
    .ads_n   (ads_n),
    .be_n    (be_n),
    .mio     (mio),
    .dc      (dc),
    .wr      (wr),
    .bus_oe  (bus_oe),
    .data_oe (data_oe),
    .hlda    (hlda),
    .resume  (resume)
);

// File: tb/tb_halt_cycle_ctrl.sv
module tb_halt_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_req = 1'b0;
    logic        shut_req = 1'b0;
    logic        rdy_n = 1'b1;
    logic        intr = 1'b0;
    logic        if_flag = 1'b0;
    logic        nmi = 1'b0;
    logic        hold = 1'b0;
    logic        ads_n;
    logic [3:0]  be_n;
    logic        mio;
    logic        dc;
    logic        wr;
    logic [29:0] addr;
    logic [31:0] data;
    logic        bus_oe;
    logic        data_oe;
    logic        hlda;
    logic        resume;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] BE_HALT = 4'b1011;
    localparam logic [3:0] BE_SHUT = 4'b1110;
    localparam logic [3:0] BE_NONE = 4'b1111;

    always #10 clk = ~clk;

    halt_cycle_ctrl dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .shut_req(shut_req),
        .rdy_n(rdy_n), .intr(intr), .if_flag(if_flag), .nmi(nmi), .hold(hold),
        .ads_n(ads_n), .be_n(be_n), .mio(mio), .dc(dc), .wr(wr), .addr(addr),
        .data(data), .bus_oe(bus_oe), .data_oe(data_oe), .hlda(hlda),
        .resume(resume)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "ads_n", 32'(ads_n), 32'd1);
        chk(req, "be_n", 32'(be_n), 32'(BE_NONE));
        chk(req, "data_oe", 32'(data_oe), 32'd0);
        chk(req, "hlda", 32'(hlda), 32'd0);
        chk(req, "resume", 32'(resume), 32'd0);
    endtask

    // drive a complete special cycle from idle into the halted state
    task automatic enter_halt(input bit shut);
        if (shut) shut_req = 1'b1; else halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        shut_req = 1'b0;
        tick();
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        #1;
        chk_idle("R1");
        chk("R1", "bus_oe", 32'(bus_oe), 32'd1);
        tick();
        rst = 1'b0;
        tick();
        chk_idle("R1");
    endtask

    task automatic t_halt_basic();
        halt_req = 1'b1;
        tick();
        chk("R2", "ads_n T1", 32'(ads_n), 32'd0);
        chk("R2", "mio", 32'(mio), 32'd1);
        chk("R2", "dc", 32'(dc), 32'd0);
        chk("R2", "wr", 32'(wr), 32'd1);
        chk("R2", "addr", 32'(addr), 32'd0);
        chk("R2", "data_oe", 32'(data_oe), 32'd1);
        chk("R3", "be_n halt", 32'(be_n), 32'(BE_HALT));
        halt_req = 1'b0;
        rdy_n = 1'b0;  // ready during T1 must not shorten the cycle
        tick();
        chk("R5", "T1 ready ignored data_oe", 32'(data_oe), 32'd1);
        chk("R2", "ads_n single cycle", 32'(ads_n), 32'd1);
        rdy_n = 1'b1;
        tick();
        tick();
        chk("R4", "wait data_oe", 32'(data_oe), 32'd1);
        chk("R4", "wait ads_n", 32'(ads_n), 32'd1);
        chk("R4", "wait be_n", 32'(be_n), 32'(BE_HALT));
        chk("R4", "wait mio", 32'(mio), 32'd1);
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        chk("R5", "halted data_oe", 32'(data_oe), 32'd0);
        chk("R5", "halted be_n", 32'(be_n), 32'(BE_NONE));
    endtask

    task automatic t_masked_and_wake();
        intr = 1'b1;
        if_flag = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6", "masked intr resume", 32'(resume), 32'd0);
            chk("R6", "masked intr ads_n", 32'(ads_n), 32'd1);
        end
        halt_req = 1'b1;
        tick();
        chk("R6", "halt_req ignored ads_n", 32'(ads_n), 32'd1);
        halt_req = 1'b0;
        if_flag = 1'b1;
        tick();
        chk("R7", "intr wake resume", 32'(resume), 32'd1);
        intr = 1'b0;
        if_flag = 1'b0;
        tick();
        chk("R7", "resume one cycle", 32'(resume), 32'd0);
        chk_idle("R7");
    endtask

    task automatic t_shutdown();
        halt_req = 1'b1;
        shut_req = 1'b1;
        tick();
        chk("R3", "be_n shutdown wins", 32'(be_n), 32'(BE_SHUT));
        chk("R3", "shutdown ads_n", 32'(ads_n), 32'd0);
        halt_req = 1'b0;
        shut_req = 1'b0;
        tick();
        chk("R3", "shutdown T2 be_n", 32'(be_n), 32'(BE_SHUT));
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        chk("R5", "shutdown done", 32'(data_oe), 32'd0);
        nmi = 1'b1;
        tick();
        nmi = 1'b0;
        chk("R7", "nmi resume", 32'(resume), 32'd1);
        tick();
        chk("R7", "nmi resume ends", 32'(resume), 32'd0);
    endtask

    task automatic t_hold_idle();
        hold = 1'b1;
        tick();
        chk("R8", "idle hlda", 32'(hlda), 32'd1);
        chk("R8", "idle bus_oe", 32'(bus_oe), 32'd0);
        halt_req = 1'b1;
        tick();
        chk("R11", "no cycle in hold", 32'(ads_n), 32'd1);
        chk("R11", "hlda kept", 32'(hlda), 32'd1);
        hold = 1'b0;
        tick();
        chk("R8", "hlda released", 32'(hlda), 32'd0);
        chk("R11", "idle after release", 32'(ads_n), 32'd1);
        tick();
        chk("R11", "cycle starts", 32'(ads_n), 32'd0);
        halt_req = 1'b0;
        tick();
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        chk("R5", "halted after hold", 32'(data_oe), 32'd0);
    endtask

    task automatic t_hold_halted();
        hold = 1'b1;
        tick();
        chk("R8", "halted hlda", 32'(hlda), 32'd1);
        chk("R8", "halted bus_oe", 32'(bus_oe), 32'd0);
        hold = 1'b0;
        tick();
        chk("R8", "halted hlda drop", 32'(hlda), 32'd0);
        chk("R8", "no resume", 32'(resume), 32'd0);
        tick();
        chk("R8", "still halted", 32'(resume), 32'd0);
        chk("R8", "still halted ads_n", 32'(ads_n), 32'd1);
        nmi = 1'b1;
        tick();
        nmi = 1'b0;
        chk("R7", "wake after hold", 32'(resume), 32'd1);
        tick();
    endtask

    task automatic t_hold_in_cycle();
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        hold = 1'b1;
        tick();
        chk("R9", "T2 no hlda", 32'(hlda), 32'd0);
        chk("R9", "T2 data_oe", 32'(data_oe), 32'd1);
        tick();
        chk("R9", "T2 still no hlda", 32'(hlda), 32'd0);
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        chk("R9", "hlda at completion", 32'(hlda), 32'd1);
        nmi = 1'b1;
        tick();
        nmi = 1'b0;
        chk("R10", "no resume in hold", 32'(resume), 32'd0);
        chk("R10", "hlda held", 32'(hlda), 32'd1);
        tick();
        hold = 1'b0;
        tick();
        chk("R10", "pending wake resume", 32'(resume), 32'd1);
        chk("R10", "hlda off", 32'(hlda), 32'd0);
        tick();
        chk("R10", "resume ends", 32'(resume), 32'd0);
    endtask

    task automatic t_same_cycle();
        enter_halt(1'b0);
        hold = 1'b1;
        intr = 1'b1;
        if_flag = 1'b1;
        tick();
        intr = 1'b0;
        if_flag = 1'b0;
        chk("R10", "same cycle hlda", 32'(hlda), 32'd1);
        chk("R10", "same cycle resume", 32'(resume), 32'd0);
        tick();
        hold = 1'b0;
        tick();
        chk("R10", "same cycle resume later", 32'(resume), 32'd1);
        tick();
    endtask

    task automatic t_reset_mid();
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        tick();
        rst = 1'b1;
        #1;
        chk_idle("R1");
        chk("R1", "bus_oe mid reset", 32'(bus_oe), 32'd1);
        tick();
        rst = 1'b0;
        hold = 1'b1;
        tick();
        chk("R8", "hlda before reset", 32'(hlda), 32'd1);
        rst = 1'b1;
        #1;
        chk("R1", "reset drops hlda", 32'(hlda), 32'd0);
        hold = 1'b0;
        tick();
        rst = 1'b0;
        tick();
        chk_idle("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        enter_halt(1'b0);
        chk("R5", "enter halted", 32'(data_oe), 32'd0);
        t_masked_and_wake();
        t_halt_basic();
        t_masked_and_wake();
        t_shutdown();
        t_hold_idle();
        t_hold_halted();
        t_hold_in_cycle();
        t_same_cycle();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule